// File: doc/BRIEF.md
# System Control and Fault Register File

This block is the memory-mapped system control register set of a small microcontroller core. Software reaches it over a simple 32-bit register bus with a byte address whose two low bits are ignored, and each access carries a privilege flag. The block keeps the configuration control word, three sticky fault status words, two fault address words, the vector table base, and the enables of the three configurable fault handlers. It also decodes a software trigger register that hands an interrupt number to an external interrupt controller.

The core raises fault causes on three set buses, one per status word. Software clears the causes it has handled by writing ones. A small bus state machine has two states: IDLE, when no response is due, and ACK, when a response is presented. A request in either state moves it to ACK, which accepts back-to-back requests. With no request it returns to IDLE. Each request completes in the cycle after it is accepted. Writes take effect on the accepting edge. Reads return the value held before that edge.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, every stored register is zero, and `rsp_valid` and `pend_valid` are low.
- R2: A request sampled with `req_valid` high gives `rsp_valid` high in the next cycle. A read of an unmapped offset returns zero, and a write to one changes no register.
- R3: A write to the configuration word at 0xd14 keeps only bits 9, 8, 4, 3, 1 and 0: stack align, bus-error ignore, divide trap, unaligned trap, user pend enable, and thread re-entry enable. Every other bit reads zero.
- R4: The status words at 0xd28, 0xd2c and 0xd30 are write-one-to-clear. Each written 1 clears its bit, and each written 0 leaves its bit unchanged.
- R5: A set bus ORs its bits into its status word each cycle. When a set and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R6: The fault address words at 0xd34 (memory manage) and 0xd38 (bus) read back the last value written.
- R7: The auxiliary status word at 0xd3c always reads zero and ignores writes.
- R8: A write to the vector base at 0xd08 stores the value with bits 6:0 forced to zero.
- R9: A write to 0xf00 pulses `pend_valid` for one cycle, in the cycle after acceptance, with `pend_irq` = wdata[8:0]. This happens only when that number is below `NUM_IRQ` and either `req_priv` is high or bit 1 of the configuration word is set. Otherwise nothing is raised.
- R10: A read of 0xd04 returns `core_exc_num` in bits 8:0, or 0 when `core_exc_num` is 1023. All other bits read zero.
- R11: Offset 0xd0c reads 0xfa050000, and offset 0x1c reads 10000.
- R12: At 0xd24, bits 16, 17 and 18 are writable enables for the memory-manage, bus and usage fault handlers, driven out on `fault_hnd_en[2:0]`. Bit 0 reads `mm_fault_active`. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Response valid (one cycle after acceptance) |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| core_exc_num | input | 10 | Active exception number from the core |
| mm_fault_active | input | 1 | Memory-manage handler active flag |
| cfsr_set | input | 32 | Configurable fault cause set bits |
| hfsr_set | input | 32 | Hard fault cause set bits |
| dfsr_set | input | 32 | Debug fault cause set bits |
| pend_valid | output | 1 | Software pend request strobe |
| pend_irq | output | 9 | IRQ number of the pend request |
| ccr_value | output | 32 | Current configuration word |
| vtor_value | output | 32 | Current vector table base |
| fault_hnd_en | output | 3 | Fault handler enables {usage, bus, mem} |

## Verification
The bench targets the same-cycle collision of a hardware set with a software clear. A design that lets the clear win would lose a freshly reported fault. It checks that zeros written to a status word leave it untouched, since a plain store would wipe unrelated causes. The software trigger is driven at the IRQ count boundary (63 against 64), from unprivileged code with the user pend enable off and then on, and with junk in the upper write bits. A wrong gate or truncation would either raise spurious pends or drop legal ones. It also reads the active vector at 1023 and at an ordinary number, and writes all ones to the configuration and vector words so that any unmasked bit shows up in the readback.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int IRQ_W   = 9;
    localparam int N_STAT  = 3;

    localparam logic [ADDR_W-1:0] OFF_CALIB  = 12'h01c;
    localparam logic [ADDR_W-1:0] OFF_ICSR   = 12'hd04;
    localparam logic [ADDR_W-1:0] OFF_VTOR   = 12'hd08;
    localparam logic [ADDR_W-1:0] OFF_AIRCR  = 12'hd0c;
    localparam logic [ADDR_W-1:0] OFF_CCR    = 12'hd14;
    localparam logic [ADDR_W-1:0] OFF_SHCSR  = 12'hd24;
    localparam logic [ADDR_W-1:0] OFF_CFSR   = 12'hd28;
    localparam logic [ADDR_W-1:0] OFF_HFSR   = 12'hd2c;
    localparam logic [ADDR_W-1:0] OFF_DFSR   = 12'hd30;
    localparam logic [ADDR_W-1:0] OFF_MMAR   = 12'hd34;
    localparam logic [ADDR_W-1:0] OFF_BFAR   = 12'hd38;
    localparam logic [ADDR_W-1:0] OFF_AUX    = 12'hd3c;
    localparam logic [ADDR_W-1:0] OFF_SWTRIG = 12'hf00;

    localparam logic [DATA_W-1:0] CCR_KEEP    = 32'h0000_031b;
    localparam int                CCR_UPEND   = 1;
    localparam logic [DATA_W-1:0] AIRCR_CONST = 32'hfa05_0000;
    localparam logic [DATA_W-1:0] CALIB_CONST = 32'd10000;
    localparam logic [9:0]        EXC_NONE    = 10'd1023;
    localparam int                SH_EN_LSB   = 16;

endpackage

// File: rtl/sysctl_bus_fsm.sv
module sysctl_bus_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic accept,
    output logic rsp_valid
);

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = req_valid ? BUS_ACK : BUS_IDLE;
            BUS_ACK:  state_d = req_valid ? BUS_ACK : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept    = req_valid;
        rsp_valid = (state_q == BUS_ACK);
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == 1'b0) |=> !rsp_valid);

endmodule

// File: rtl/sysctl_w1c_reg.sv
module sysctl_w1c_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] stat_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> (($past(set_i) & ~stat_q) == '0));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> (($past(clr_i & ~set_i) & stat_q) == '0));

    // R4
    zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q & ~clr_i) & ~stat_q) == '0));

endmodule

// File: rtl/sysctl_swtrig.sv
module sysctl_swtrig
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             priv,
    input  logic             user_pend_en,
    input  logic [IRQ_W-1:0] irq_num,
    output logic             pend_valid,
    output logic [IRQ_W-1:0] pend_irq
);

    logic in_range;
    logic allowed;

    always_comb begin
        in_range = (32'(irq_num) < NUM_IRQ);
        allowed  = priv || user_pend_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_irq   <= '0;
        end else begin
            pend_valid <= hit && in_range && allowed;
            if (hit && in_range && allowed) pend_irq <= irq_num;
        end
    end

    // R9
    pend_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (32'(pend_irq) < NUM_IRQ));

    // R9
    pend_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !pend_valid);

    // R9
    pend_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !priv && !user_pend_en) |=> !pend_valid);

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int VTOR_ALIGN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [9:0]        core_exc_num,
    input  logic              mm_fault_active,
    input  logic [DATA_W-1:0] cfsr_set,
    input  logic [DATA_W-1:0] hfsr_set,
    input  logic [DATA_W-1:0] dfsr_set,
    output logic              pend_valid,
    output logic [IRQ_W-1:0]  pend_irq,
    output logic [DATA_W-1:0] ccr_value,
    output logic [DATA_W-1:0] vtor_value,
    output logic [2:0]        fault_hnd_en
);

    localparam logic [DATA_W-1:0] VTOR_MASK = ~((DATA_W'(1) << VTOR_ALIGN) - 1);
    localparam int WA = ADDR_W - 2;

    logic              accept;
    logic              wr_en;
    logic              rd_en;
    logic [WA-1:0]     widx;
    logic [DATA_W-1:0] ccr_q, vtor_q, mmar_q, bfar_q;
    logic [2:0]        hnd_en_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    logic [ADDR_W-1:0] stat_off [N_STAT];
    logic [DATA_W-1:0] stat_set [N_STAT];
    logic [DATA_W-1:0] stat_clr [N_STAT];
    logic [DATA_W-1:0] stat_val [N_STAT];

    sysctl_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .accept    (accept),
        .rsp_valid (rsp_valid)
    );

    always_comb begin
        wr_en = accept && req_write;
        rd_en = accept && !req_write;
        widx  = req_addr[ADDR_W-1:2];
    end

    always_comb begin
        stat_off[0] = OFF_CFSR;
        stat_off[1] = OFF_HFSR;
        stat_off[2] = OFF_DFSR;
        stat_set[0] = cfsr_set;
        stat_set[1] = hfsr_set;
        stat_set[2] = dfsr_set;
    end

    for (genvar g = 0; g < N_STAT; g++) begin : g_stat
        always_comb begin
            stat_clr[g] = (wr_en && widx == stat_off[g][ADDR_W-1:2]) ? req_wdata : '0;
        end

        sysctl_w1c_reg #(.WIDTH(DATA_W)) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (stat_set[g]),
            .clr_i  (stat_clr[g]),
            .stat_q (stat_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q    <= '0;
            vtor_q   <= '0;
            mmar_q   <= '0;
            bfar_q   <= '0;
            hnd_en_q <= '0;
        end else if (wr_en) begin
            if (widx == OFF_CCR[ADDR_W-1:2])   ccr_q    <= req_wdata & CCR_KEEP;
            if (widx == OFF_VTOR[ADDR_W-1:2])  vtor_q   <= req_wdata & VTOR_MASK;
            if (widx == OFF_MMAR[ADDR_W-1:2])  mmar_q   <= req_wdata;
            if (widx == OFF_BFAR[ADDR_W-1:2])  bfar_q   <= req_wdata;
            if (widx == OFF_SHCSR[ADDR_W-1:2]) hnd_en_q <= req_wdata[SH_EN_LSB +: 3];
        end
    end

    sysctl_swtrig #(.NUM_IRQ(NUM_IRQ)) u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (wr_en && widx == OFF_SWTRIG[ADDR_W-1:2]),
        .priv         (req_priv),
        .user_pend_en (ccr_q[CCR_UPEND]),
        .irq_num      (req_wdata[IRQ_W-1:0]),
        .pend_valid   (pend_valid),
        .pend_irq     (pend_irq)
    );

    always_comb begin
        rd_mux = '0;
        case (widx)
            OFF_CALIB[ADDR_W-1:2]: rd_mux = CALIB_CONST;
            OFF_ICSR[ADDR_W-1:2]:
                rd_mux[8:0] = (core_exc_num == EXC_NONE) ? 9'd0 : core_exc_num[8:0];
            OFF_VTOR[ADDR_W-1:2]:  rd_mux = vtor_q;
            OFF_AIRCR[ADDR_W-1:2]: rd_mux = AIRCR_CONST;
            OFF_CCR[ADDR_W-1:2]:   rd_mux = ccr_q;
            OFF_SHCSR[ADDR_W-1:2]: begin
                rd_mux[SH_EN_LSB +: 3] = hnd_en_q;
                rd_mux[0]              = mm_fault_active;
            end
            OFF_CFSR[ADDR_W-1:2]:  rd_mux = stat_val[0];
            OFF_HFSR[ADDR_W-1:2]:  rd_mux = stat_val[1];
            OFF_DFSR[ADDR_W-1:2]:  rd_mux = stat_val[2];
            OFF_MMAR[ADDR_W-1:2]:  rd_mux = mmar_q;
            OFF_BFAR[ADDR_W-1:2]:  rd_mux = bfar_q;
            default:               rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
        else            rdata_q <= '0;
    end

    always_comb begin
        rsp_rdata    = rdata_q;
        ccr_value    = ccr_q;
        vtor_value   = vtor_q;
        fault_hnd_en = hnd_en_q;
    end

    // R3
    ccr_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_value & ~CCR_KEEP) == '0);

    // R8
    vtor_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vtor_value & ~VTOR_MASK) == '0);

    // R2
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_priv = 1'b1;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [9:0]  core_exc_num = '0;
    logic        mm_fault_active = 1'b0;
    logic [31:0] cfsr_set = '0, hfsr_set = '0, dfsr_set = '0;
    logic        pend_valid;
    logic [8:0]  pend_irq;
    logic [31:0] ccr_value, vtor_value;
    logic [2:0]  fault_hnd_en;

    int n_chk = 0;
    int n_bad = 0;
    logic        last_pv;
    logic [8:0]  last_pi;
    logic        last_rv;

    always #5 clk = ~clk;

    sysctl_regs #(.NUM_IRQ(64), .VTOR_ALIGN(7)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_exc_num(core_exc_num),
        .mm_fault_active(mm_fault_active), .cfsr_set(cfsr_set), .hfsr_set(hfsr_set),
        .dfsr_set(dfsr_set), .pend_valid(pend_valid), .pend_irq(pend_irq),
        .ccr_value(ccr_value), .vtor_value(vtor_value), .fault_hnd_en(fault_hnd_en)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        last_pv = pend_valid; last_pi = pend_irq; last_rv = rsp_valid;
        req_priv = 1'b1;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; last_rv = rsp_valid;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 pend_valid", {31'd0, pend_valid}, 32'd0);
        check("R1 ccr", ccr_value, 32'd0);
        check("R1 vtor", vtor_value, 32'd0);
        bus_read(12'hd28, d);
        check("R1 cfsr", d, 32'd0);
        bus_read(12'hd34, d);
        check("R1 mmar", d, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(12'h100, 32'hffff_ffff, 1'b1);
        check("R2 rsp_valid after write", {31'd0, last_rv}, 32'd1);
        bus_read(12'h100, d);
        check("R2 unmapped read", d, 32'd0);
        check("R2 rsp_valid after read", {31'd0, last_rv}, 32'd1);
        check("R2 unmapped write keeps ccr", ccr_value, 32'd0);
        @(negedge clk);
        check("R2 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_ccr();
        logic [31:0] d;
        bus_write(12'hd14, 32'hffff_ffff, 1'b1);
        bus_read(12'hd14, d);
        check("R3 ccr all-ones", d, 32'h0000_031b);
        bus_write(12'hd14, 32'h0000_0010, 1'b1);
        check("R3 ccr single bit", ccr_value, 32'h0000_0010);
        bus_write(12'hd14, 32'h0000_0000, 1'b1);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        @(negedge clk);
        cfsr_set = 32'h0000_0f0f; hfsr_set = 32'h4000_0002; dfsr_set = 32'h0000_001f;
        @(negedge clk);
        cfsr_set = '0; hfsr_set = '0; dfsr_set = '0;
        bus_read(12'hd28, d);
        check("R5 cfsr set", d, 32'h0000_0f0f);
        bus_write(12'hd28, 32'h0000_0101, 1'b1);
        bus_read(12'hd28, d);
        check("R4 cfsr w1c", d, 32'h0000_0e0e);
        bus_write(12'hd2c, 32'h0000_0000, 1'b1);
        bus_read(12'hd2c, d);
        check("R4 hfsr zeros keep", d, 32'h4000_0002);
        bus_write(12'hd2c, 32'h4000_0000, 1'b1);
        bus_read(12'hd2c, d);
        check("R4 hfsr w1c", d, 32'h0000_0002);
        bus_write(12'hd30, 32'h0000_0005, 1'b1);
        bus_read(12'hd30, d);
        check("R4 dfsr w1c", d, 32'h0000_001a);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        bus_write(12'hd30, 32'hffff_ffff, 1'b1);
        @(negedge clk);
        dfsr_set = 32'h0000_0041;
        @(negedge clk);
        dfsr_set = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'hd30; req_wdata = 32'h0000_0060;
        dfsr_set = 32'h0000_0020;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; dfsr_set = '0;
        bus_read(12'hd30, d);
        check("R5 set beats clear", d, 32'h0000_0021);
    endtask

    task automatic t_addr_regs();
        logic [31:0] d;
        bus_write(12'hd34, 32'hdead_beef, 1'b1);
        bus_write(12'hd38, 32'h1234_5677, 1'b1);
        bus_read(12'hd34, d);
        check("R6 mmar", d, 32'hdead_beef);
        bus_read(12'hd38, d);
        check("R6 bfar", d, 32'h1234_5677);
    endtask

    task automatic t_aux();
        logic [31:0] d;
        bus_write(12'hd3c, 32'hffff_ffff, 1'b1);
        bus_read(12'hd3c, d);
        check("R7 aux", d, 32'd0);
    endtask

    task automatic t_vtor();
        logic [31:0] d;
        bus_write(12'hd08, 32'hffff_ffff, 1'b1);
        bus_read(12'hd08, d);
        check("R8 vtor read", d, 32'hffff_ff80);
        bus_write(12'hd08, 32'h2000_017f, 1'b1);
        check("R8 vtor out", vtor_value, 32'h2000_0100);
    endtask

    task automatic t_swtrig();
        bus_write(12'hf00, 32'd5, 1'b1);
        check("R9 priv pend", {31'd0, last_pv}, 32'd1);
        check("R9 priv irq", {23'd0, last_pi}, 32'd5);
        @(negedge clk);
        check("R9 one-cycle", {31'd0, pend_valid}, 32'd0);
        bus_write(12'hf00, 32'd7, 1'b0);
        check("R9 user blocked", {31'd0, last_pv}, 32'd0);
        bus_write(12'hd14, 32'h0000_0002, 1'b1);
        bus_write(12'hf00, 32'd7, 1'b0);
        check("R9 user allowed", {31'd0, last_pv}, 32'd1);
        check("R9 user irq", {23'd0, last_pi}, 32'd7);
        bus_write(12'hf00, 32'd64, 1'b1);
        check("R9 out of range", {31'd0, last_pv}, 32'd0);
        bus_write(12'hf00, 32'd63, 1'b1);
        check("R9 top irq", {31'd0, last_pv}, 32'd1);
        check("R9 top irq num", {23'd0, last_pi}, 32'd63);
        bus_write(12'hf00, 32'hffff_fe05, 1'b1);
        check("R9 upper bits ignored", {22'd0, last_pv, last_pi}, 32'h0000_0205);
        bus_write(12'hd14, 32'h0000_0000, 1'b1);
    endtask

    task automatic t_icsr();
        logic [31:0] d;
        core_exc_num = 10'd1023;
        bus_read(12'hd04, d);
        check("R10 icsr 1023", d, 32'd0);
        core_exc_num = 10'd300;
        bus_read(12'hd04, d);
        check("R10 icsr 300", d, 32'd300);
        core_exc_num = 10'd0;
    endtask

    task automatic t_consts();
        logic [31:0] d;
        bus_write(12'hd0c, 32'h0, 1'b1);
        bus_read(12'hd0c, d);
        check("R11 aircr", d, 32'hfa05_0000);
        bus_read(12'h01c, d);
        check("R11 calib", d, 32'd10000);
    endtask

    task automatic t_shcsr();
        logic [31:0] d;
        bus_write(12'hd24, 32'hffff_ffff, 1'b1);
        check("R12 enables out", {29'd0, fault_hnd_en}, 32'd7);
        mm_fault_active = 1'b0;
        bus_read(12'hd24, d);
        check("R12 shcsr read", d, 32'h0007_0000);
        bus_write(12'hd24, 32'h0002_0000, 1'b1);
        mm_fault_active = 1'b1;
        bus_read(12'hd24, d);
        check("R12 bus only + active", d, 32'h0002_0001);
        mm_fault_active = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_ccr();
        t_w1c();
        t_set_wins();
        t_addr_regs();
        t_aux();
        t_vtor();
        t_swtrig();
        t_icsr();
        t_consts();
        t_shcsr();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule